// File: doc/BRIEF.md
# Super I/O Configuration Port

This block is the configuration front end of a multi-function peripheral chip. It decodes a pair of adjacent byte addresses on a simple 8-bit strobe bus. The lower address carries a register index. The upper address carries that register's data. A strap input selects whether the pair sits at 0x2E/0x2F or at 0x4E/0x4F.

The port comes out of reset locked. It opens only after the host writes the enter key 0x87 to the index address twice in a row, and it closes again when the host writes the exit key 0xAA there. While the port is open, a global register selects a logical device. The activate bit and the device-specific window then act on that device. Accesses to the window at indices 0xF0 to 0xFF are forwarded to the devices on a small register bus. A dedicated output tells the watchdog (logical device 8) that it has been activated.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, every activate bit is 0, `wdog_active` is 0, and `host_rdata` is 0x00 whenever no read of the port is in progress.
- R2: The port unlocks on the clock edge of the second of two consecutive index-address writes of 0x87. Any other byte written to the index address in between restarts the key sequence. Data-address accesses do not count toward the sequence.
- R3: While unlocked, an index-address write of 0xAA locks the port and does not change the stored index.
- R4: While locked, data-address writes have no effect, and reads of either port address return 0xFF.
- R5: With `alt_base` = 0 the port answers at 0x2E (index) and 0x2F (data). With `alt_base` = 1 it answers at 0x4E and 0x4F. Accesses to any other address change nothing and read 0x00.
- R6: While unlocked, an index-address write other than 0xAA stores the byte as the index, and a read of the index address returns it.
- R7: Index 0x07 is a read/write 8-bit logical device number, reset to 0x00, and it drives `dev_ldn`.
- R8: Index 0x20 reads the chip ID (parameter, default 0xC5). Writes to it are ignored.
- R9: Index 0x30 bit 0 is the activate bit of the logical device selected by index 0x07 and is held separately per device. Bits 7:1 read 0. For a device number ≥ NUM_LDEV (16), the bit reads 0 and writes are ignored. `dev_active[n]` shows device n's bit.
- R10: While unlocked, a data-address access with index 0xF0 to 0xFF is forwarded in the same cycle. A write pulses `dev_wr` with `dev_idx`, `dev_wdata` and `dev_ldn` valid. A read pulses `dev_rd` and returns `dev_rdata`. No other access pulses either strobe.
- R11: Data reads at indices that are not implemented return 0x00, and data writes to them change nothing.
- R12: `wdog_active` equals the activate bit of logical device 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_base | input | 1 | Base strap: 0 selects 0x2E, 1 selects 0x4E |
| host_addr | input | ADDR_W (16) | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, combinational during `host_rd` |
| dev_ldn | output | 8 | Selected logical device number |
| dev_idx | output | 8 | Current register index for the device bus |
| dev_wr | output | 1 | Device register write strobe |
| dev_rd | output | 1 | Device register read strobe |
| dev_wdata | output | 8 | Device write byte |
| dev_rdata | input | 8 | Device read byte |
| dev_active | output | NUM_LDEV (16) | Activate bit per logical device |
| wdog_active | output | 1 | Activate bit of the watchdog device |

## Verification
The bench goes after interrupted key sequences. A design that only counts 0x87 bytes, without requiring them to be consecutive, would unlock after 0x87, 0x12, 0x87 when it should stay locked. It also checks that the exit key does not overwrite the index, that locked data writes leave the device-number and activate state untouched, and that index and data reads return 0xFF while locked. A mis-gated device strobe would show up as spurious `dev_wr` pulses. The bench selects devices at and above NUM_LDEV and reads activate bits back after switching devices. A design sharing one activate bit across devices, or wrapping large device numbers, would report the wrong bit or light the wrong `dev_active` line.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  CHIP_ID   = 8'hC5,
  parameter int          NUM_LDEV  = 16,
  parameter int          WDT_LDN   = 8,
  parameter logic [7:0]  KEY_ENTER = 8'h87,
  parameter logic [7:0]  KEY_EXIT  = 8'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alt_base,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic [7:0]        dev_ldn,
  output logic [7:0]        dev_idx,
  output logic              dev_wr,
  output logic              dev_rd,
  output logic [7:0]        dev_wdata,
  input  logic [7:0]        dev_rdata,
  output logic [NUM_LDEV-1:0] dev_active,
  output logic              wdog_active
);
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
  localparam logic [ADDR_W-1:0] BASE_LO = ADDR_W'(16'h002E);
  localparam logic [ADDR_W-1:0] BASE_HI = ADDR_W'(16'h004E);
  localparam logic [7:0] IDX_LDN = 8'h07;
  localparam logic [7:0] IDX_ID  = 8'h20;
  localparam logic [7:0] IDX_ACT = 8'h30;

  logic              unlocked, key_half;
  logic [7:0]        idx_q, ldn_q;
  logic [NUM_LDEV-1:0] act_q;
  logic [ADDR_W-1:0] base;
  logic              idx_hit, dat_hit, cfg_wr, cfg_rd, in_dev_win, ldn_ok;
  logic [7:0]        reg_rd;

  assign base       = alt_base ? BASE_HI : BASE_LO;
  assign idx_hit    = (host_addr == base);
  assign dat_hit    = (host_addr == base + ADDR_W'(1));
  assign cfg_wr     = host_wr && unlocked && dat_hit;
  assign cfg_rd     = host_rd && unlocked && dat_hit;
  assign in_dev_win = (idx_q[7:4] == 4'hF);
  assign ldn_ok     = (int'(ldn_q) < NUM_LDEV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      key_half <= 1'b0;
      idx_q    <= 8'h00;
    end else if (host_wr && idx_hit) begin
      if (!unlocked) begin
        if (host_wdata == KEY_ENTER) begin
          unlocked <= key_half;
          key_half <= !key_half;
        end else begin
          key_half <= 1'b0;
        end
      end else if (host_wdata == KEY_EXIT) begin
        unlocked <= 1'b0;
        key_half <= 1'b0;
      end else begin
        idx_q <= host_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q <= 8'h00;
      act_q <= '0;
    end else if (cfg_wr) begin
      if (idx_q == IDX_LDN) ldn_q <= host_wdata;
      if (idx_q == IDX_ACT && ldn_ok) act_q[ldn_q[LDN_W-1:0]] <= host_wdata[0];
    end
  end

  always_comb begin
    reg_rd = 8'h00;
    if (in_dev_win) reg_rd = dev_rdata;
    else begin
      case (idx_q)
        IDX_LDN: reg_rd = ldn_q;
        IDX_ID:  reg_rd = CHIP_ID;
        IDX_ACT: reg_rd = ldn_ok ? {7'b0, act_q[ldn_q[LDN_W-1:0]]} : 8'h00;
        default: reg_rd = 8'h00;
      endcase
    end
  end

  always_comb begin
    host_rdata = 8'h00;
    if (host_rd && (idx_hit || dat_hit)) begin
      if (!unlocked)    host_rdata = 8'hFF;
      else if (idx_hit) host_rdata = idx_q;
      else              host_rdata = reg_rd;
    end
  end

  assign dev_ldn     = ldn_q;
  assign dev_idx     = idx_q;
  assign dev_wdata   = host_wdata;
  assign dev_wr      = cfg_wr && in_dev_win;
  assign dev_rd      = cfg_rd && in_dev_win;
  assign dev_active  = act_q;
  assign wdog_active = act_q[WDT_LDN];

  // R2
  unlock_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(host_wr && idx_hit && host_wdata == KEY_ENTER));

  // R3
  exit_key_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && host_wr && idx_hit && host_wdata == KEY_EXIT) |=> (!unlocked && $stable(idx_q)));

  // R4
  locked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> (!dev_wr && !dev_rd));

  // R4
  locked_state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && !$rose(unlocked)) |=> ($stable(ldn_q) && $stable(act_q)));

  // R9
  one_active_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_q ^ $past(act_q)) <= 1);

  // R12
  wdog_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_active == dev_active[WDT_LDN]);
endmodule

// File: tb/sio_cfg_port_tb.sv
module sio_cfg_port_tb;
  logic clk = 0, rst_n = 0, alt_base = 0;
  logic [15:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata, dev_ldn, dev_idx, dev_wdata, dev_rdata;
  logic dev_wr, dev_rd, wdog_active;
  logic [15:0] dev_active;
  int checks = 0, fails = 0;
  logic done = 0;

  logic m_unl, m_half;
  logic [7:0] m_idx, m_ldn;
  logic [15:0] m_act;

  always #5 clk = ~clk;

  assign dev_rdata = dev_rd ? ({dev_ldn[3:0], dev_idx[3:0]} ^ 8'h5A) : 8'h00;

  sio_cfg_port u_dut (.clk(clk), .rst_n(rst_n), .alt_base(alt_base), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dev_ldn(dev_ldn), .dev_idx(dev_idx), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_active(dev_active),
    .wdog_active(wdog_active));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] base_of();
    return alt_base ? 16'h004E : 16'h002E;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    logic [15:0] b = base_of();
    if (a != b && a != b + 1) return 8'h00;
    if (!m_unl) return 8'hFF;
    if (a == b) return m_idx;
    if (m_idx[7:4] == 4'hF) return {m_ldn[3:0], m_idx[3:0]} ^ 8'h5A;
    case (m_idx)
      8'h07: return m_ldn;
      8'h20: return 8'hC5;
      8'h30: return (m_ldn < 16) ? {7'b0, m_act[m_ldn[3:0]]} : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_tag(input logic [15:0] a);
    logic [15:0] b = base_of();
    if (a != b && a != b + 1) return "R5";
    if (!m_unl) return "R4";
    if (a == b) return "R6";
    if (m_idx[7:4] == 4'hF) return "R10";
    case (m_idx)
      8'h07: return "R7";
      8'h20: return "R8";
      8'h30: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model_reset();
    m_unl = 0; m_half = 0; m_idx = 0; m_ldn = 0; m_act = 0;
  endtask

  task automatic do_reset(input logic alt);
    @(negedge clk);
    rst_n = 0; alt_base = alt; host_wr = 0; host_rd = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic op(input logic rd, input logic wr, input logic [15:0] a, input logic [7:0] d);
    logic [15:0] b;
    logic exp_dwr;
    @(negedge clk);
    chk(dev_active == m_act, "R9 dev_active", dev_active, m_act);
    chk(wdog_active == m_act[8], "R12 wdog_active", wdog_active, m_act[8]);
    chk(dev_ldn == m_ldn, "R7 dev_ldn", dev_ldn, m_ldn);
    host_addr = a; host_wdata = d; host_rd = rd; host_wr = wr;
    #1;
    b = base_of();
    if (rd) chk(host_rdata == exp_rd(a), rd_tag(a), host_rdata, exp_rd(a));
    else chk(host_rdata == 8'h00, "R1 idle rdata", host_rdata, 0);
    chk(dev_rd == (rd && m_unl && a == b + 1 && m_idx[7:4] == 4'hF), "R10 dev_rd", dev_rd, 0);
    exp_dwr = wr && m_unl && a == b + 1 && m_idx[7:4] == 4'hF;
    chk(dev_wr == exp_dwr, "R10 dev_wr", dev_wr, exp_dwr);
    if (exp_dwr) chk(dev_wdata == d && dev_idx == m_idx, "R10 dev bus", {dev_idx, dev_wdata}, {m_idx, d});
    if (wr && a == b) begin
      if (!m_unl) begin
        if (d == 8'h87) begin m_unl = m_half; m_half = !m_half; end
        else m_half = 0;
      end else if (d == 8'hAA) begin m_unl = 0; m_half = 0; end
      else m_idx = d;
    end else if (wr && a == b + 1 && m_unl) begin
      if (m_idx == 8'h07) m_ldn = d;
      if (m_idx == 8'h30 && m_ldn < 16) m_act[m_ldn[3:0]] = d[0];
    end
    @(posedge clk);
    #1;
    host_wr = 0; host_rd = 0;
  endtask

  task automatic wr_idx(input logic [7:0] d); op(0, 1, base_of(), d); endtask
  task automatic wr_dat(input logic [7:0] d); op(0, 1, base_of() + 1, d); endtask
  task automatic rd_dat(); op(1, 0, base_of() + 1, 8'h00); endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      int sel = $urandom_range(0, 99);
      int dk = $urandom_range(0, 11);
      logic [15:0] a;
      logic [7:0] d;
      if (sel < 45) a = base_of();
      else if (sel < 90) a = base_of() + 1;
      else if (sel < 95) a = base_of() + 2;
      else a = alt_base ? 16'h002E : 16'h004F;
      case (dk)
        0, 1, 2: d = 8'h87;
        3: d = 8'hAA;
        4: d = 8'h07;
        5: d = 8'h20;
        6: d = 8'h30;
        7: d = {4'hF, 4'($urandom)};
        8: d = 8'($urandom);
        default: d = {4'h0, 4'($urandom)} | (dk == 9 ? 8'h10 : 8'h00);
      endcase
      op($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a, d);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    do_reset(0);
    // R1 reset state
    @(negedge clk);
    chk(dev_active == 0 && wdog_active == 0, "R1 reset active", dev_active, 0);
    rd_dat();
    // R4 locked writes ignored
    wr_idx(8'h87); wr_dat(8'h07);
    op(1, 0, base_of(), 0);
    // R2 interrupted sequence stays locked, then opens
    wr_idx(8'h12); wr_idx(8'h87); wr_idx(8'h33); wr_idx(8'h87);
    op(1, 0, base_of(), 0);
    wr_idx(8'h87);
    op(1, 0, base_of(), 0);
    // R7, R8, R9, R12
    wr_idx(8'h07); wr_dat(8'h08); rd_dat();
    wr_idx(8'h30); wr_dat(8'hFF); rd_dat();
    wr_idx(8'h20); wr_dat(8'h00); rd_dat();
    wr_idx(8'h07); wr_dat(8'h13); wr_idx(8'h30); wr_dat(8'h01); rd_dat();
    wr_idx(8'h07); wr_dat(8'h03); wr_idx(8'h30); rd_dat();
    // R10, R11
    wr_idx(8'hF5); wr_dat(8'h9C); rd_dat();
    wr_idx(8'h55); wr_dat(8'h77); rd_dat();
    // R3 exit keeps index, locks
    wr_idx(8'hAA); op(1, 0, base_of(), 0);
    wr_idx(8'h87); wr_idx(8'h87); op(1, 0, base_of(), 0);
    random_run(4000);
    do_reset(1);
    // R5 alternate base
    op(1, 0, 16'h002E, 0);
    wr_idx(8'h87); wr_idx(8'h87); op(1, 0, base_of(), 0);
    op(0, 1, 16'h002F, 8'h44);
    random_run(4000);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule